// File: doc/BRIEF.md
# Reorder Buffer Commit Unit

This block is the in-order retirement queue of an out-of-order core whose operand values all live in one shared physical register file. Decode claims one slot per instruction, in program order, and hands the slot number down the pipeline. Each slot holds bookkeeping only: whether the instruction writes a register, the architectural register it names, the physical tag just given to it, the physical tag that register mapped to before, and whether the instruction owns a memory-queue slot. Data values never pass through the block.

Execute units report completion by slot number, with a fault flag. Retirement looks only at the oldest slot. When that slot is finished without a fault, it retires in the same cycle: the block reports the retired slot, hands the displaced physical tag back to the free list, and releases the memory-queue slot when one was held. When the oldest slot finished with a fault, a two-state controller moves from `ST_RUN` to `ST_FLUSH`. In `ST_FLUSH` it asserts a flush for one cycle with the handler address as the new fetch target. It empties every slot, pulls the allocation point back to the faulting slot, and then returns to `ST_RUN`. The controller takes exactly two transitions: RUN to FLUSH on a faulting oldest slot, and FLUSH to RUN unconditionally.

Top module: `rob_commit`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `commit_valid`, `free_valid`, `mem_release` and `flush` are all 0.
- R2: Slots are handed out in ascending order modulo DEPTH (16), with the current slot number shown on `alloc_idx`. Once 16 slots are held and none has retired, `alloc_ready` is 0.
- R3: Only the oldest held slot may retire. While it is not finished, nothing retires, however many younger slots have finished.
- R4: A completion marks the named slot finished and records its fault flag. A completion that names a slot which is not held is ignored, and that slot stays unfinished after it is later allocated.
- R5: A retiring slot shows its number on `commit_idx`, its architectural register on `commit_arch` and its new tag on `commit_new_tag`. When it writes a register, `free_valid` is 1 and `free_tag` carries the old tag given at allocation.
- R6: A retiring slot that writes no register leaves `free_valid` at 0.
- R7: `mem_release` is 1 exactly in the cycles in which a slot allocated with `alloc_is_mem`=1 retires.
- R8: When the oldest slot is finished with a fault, it does not retire. In the following cycle `flush` is 1, `redirect_pc` equals HANDLER_PC, and `alloc_ready` is 0.
- R9: After the flush cycle the queue is empty, younger finished slots are discarded, and the next slot handed out is the faulting slot's number.
- R10: At most one slot retires per cycle, and consecutive finished slots retire in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_valid | input | 1 | Decode requests a slot |
| alloc_has_dest | input | 1 | Instruction writes a register |
| alloc_arch | input | 5 | Architectural destination |
| alloc_new_tag | input | 6 | Physical tag newly assigned |
| alloc_old_tag | input | 6 | Physical tag previously mapped |
| alloc_is_mem | input | 1 | Instruction holds a memory-queue slot |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_idx | output | 4 | Slot number given to the request |
| cmpl_valid | input | 1 | Execute reports a completion |
| cmpl_idx | input | 4 | Slot being completed |
| cmpl_exc | input | 1 | Completion carries a fault |
| commit_valid | output | 1 | A slot retires this cycle |
| commit_idx | output | 4 | Retiring slot number |
| commit_arch | output | 5 | Retiring architectural register |
| commit_new_tag | output | 6 | Retiring new physical tag |
| free_valid | output | 1 | Return `free_tag` to the free list |
| free_tag | output | 6 | Displaced physical tag |
| mem_release | output | 1 | Release the memory-queue slot |
| flush | output | 1 | Flush the pipeline |
| redirect_pc | output | 32 | Fetch target during flush |

## Verification
An allocation registers at the clock edge on which `alloc_valid` and `alloc_ready` are both high. A completion takes effect at its edge, so a finished oldest slot shows its retire outputs in the cycle that follows and leaves at the edge after that. The bench drives on the falling edge and reads each result at the next falling edge, one edge after the stimulus. A fault at the head yields no retirement in the first such cycle, `flush` one cycle later, and an empty queue a further cycle on. The bench reads these three cycles separately, so an output one cycle early or late is reported.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int ARCH_W = 5;
    localparam int TAG_W  = 6;

    typedef struct packed {
        logic              has_dest;
        logic [ARCH_W-1:0] arch;
        logic [TAG_W-1:0]  new_tag;
        logic [TAG_W-1:0]  old_tag;
        logic              is_mem;
    } slot_info_t;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } cstate_t;

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             rewind,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = IDX_W + 1;

    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] tail_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (rewind) begin
            tail_q <= head_q;
        end else begin
            if (push) tail_q <= tail_q + PTR_W'(1);
            if (pop)  head_q <= head_q + PTR_W'(1);
        end
    end

    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];
    assign empty    = (head_q == tail_q);
    assign full     = (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]) &&
                      (head_q[IDX_W] != tail_q[IDX_W]);

endmodule

// File: rtl/rob_store.sv
module rob_store
    import rob_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  slot_info_t       wr_info,
    input  logic             cmp_en,
    input  logic [IDX_W-1:0] cmp_idx,
    input  logic             cmp_exc,
    input  logic             ret_en,
    input  logic             clr_all,
    input  logic [IDX_W-1:0] rd_idx,
    output slot_info_t       rd_info,
    output logic             rd_valid,
    output logic             rd_done,
    output logic             rd_exc
);
    slot_info_t       info_mem [DEPTH];
    logic [DEPTH-1:0] held_q;
    logic [DEPTH-1:0] done_q;
    logic [DEPTH-1:0] exc_q;

    always_ff @(posedge clk) begin
        if (wr_en) info_mem[wr_idx] <= wr_info;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic hit_wr;
        logic hit_cmp;
        logic hit_ret;
        assign hit_wr  = wr_en  && (wr_idx  == IDX_W'(g));
        assign hit_cmp = cmp_en && (cmp_idx == IDX_W'(g)) && held_q[g];
        assign hit_ret = ret_en && (rd_idx  == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held_q[g] <= 1'b0;
                done_q[g] <= 1'b0;
                exc_q[g]  <= 1'b0;
            end else if (clr_all) begin
                held_q[g] <= 1'b0;
                done_q[g] <= 1'b0;
                exc_q[g]  <= 1'b0;
            end else if (hit_wr) begin
                held_q[g] <= 1'b1;
                done_q[g] <= 1'b0;
                exc_q[g]  <= 1'b0;
            end else if (hit_ret) begin
                held_q[g] <= 1'b0;
                done_q[g] <= 1'b0;
                exc_q[g]  <= 1'b0;
            end else if (hit_cmp) begin
                done_q[g] <= 1'b1;
                exc_q[g]  <= cmp_exc;
            end
        end
    end

    assign rd_info  = info_mem[rd_idx];
    assign rd_valid = held_q[rd_idx];
    assign rd_done  = done_q[rd_idx];
    assign rd_exc   = exc_q[rd_idx];

endmodule

// File: rtl/rob_commit_fsm.sv
module rob_commit_fsm
    import rob_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    head_valid,
    input  logic    head_done,
    input  logic    head_exc,
    output logic    retire,
    output logic    flush_go,
    output logic    accept
);
    cstate_t state_q;
    cstate_t state_d;
    logic    head_ready;

    assign head_ready = head_valid && head_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        retire   = 1'b0;
        flush_go = 1'b0;
        accept   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                accept = 1'b1;
                if (head_ready && head_exc) state_d = ST_FLUSH;
                else if (head_ready)        retire  = 1'b1;
            end
            ST_FLUSH: begin
                flush_go = 1'b1;
                state_d  = ST_RUN;
            end
        endcase
    end

endmodule

// File: rtl/rob_commit.sv
module rob_commit
    import rob_pkg::*;
#(
    parameter int          DEPTH      = 16,
    parameter int          PC_W       = 32,
    parameter logic [31:0] HANDLER_PC = 32'h0000_0180,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic              alloc_has_dest,
    input  logic [ARCH_W-1:0] alloc_arch,
    input  logic [TAG_W-1:0]  alloc_new_tag,
    input  logic [TAG_W-1:0]  alloc_old_tag,
    input  logic              alloc_is_mem,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              cmpl_valid,
    input  logic [IDX_W-1:0]  cmpl_idx,
    input  logic              cmpl_exc,
    output logic              commit_valid,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [ARCH_W-1:0] commit_arch,
    output logic [TAG_W-1:0]  commit_new_tag,
    output logic              free_valid,
    output logic [TAG_W-1:0]  free_tag,
    output logic              mem_release,
    output logic              flush,
    output logic [PC_W-1:0]   redirect_pc
);
    logic [IDX_W-1:0] head_idx;
    logic [IDX_W-1:0] tail_idx;
    logic             q_full;
    logic             q_empty;
    logic             take;
    logic             retire;
    logic             flush_go;
    logic             accept;
    slot_info_t       new_info;
    slot_info_t       head_info;
    logic             head_valid;
    logic             head_done;
    logic             head_exc;

    assign alloc_ready = accept && !q_full;
    assign take        = alloc_valid && alloc_ready;
    assign alloc_idx   = tail_idx;

    always_comb begin
        new_info.has_dest = alloc_has_dest;
        new_info.arch     = alloc_arch;
        new_info.new_tag  = alloc_new_tag;
        new_info.old_tag  = alloc_old_tag;
        new_info.is_mem   = alloc_is_mem;
    end

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take),
        .pop      (retire),
        .rewind   (flush_go),
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .full     (q_full),
        .empty    (q_empty)
    );

    rob_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (take),
        .wr_idx   (tail_idx),
        .wr_info  (new_info),
        .cmp_en   (cmpl_valid && !flush_go),
        .cmp_idx  (cmpl_idx),
        .cmp_exc  (cmpl_exc),
        .ret_en   (retire),
        .clr_all  (flush_go),
        .rd_idx   (head_idx),
        .rd_info  (head_info),
        .rd_valid (head_valid),
        .rd_done  (head_done),
        .rd_exc   (head_exc)
    );

    rob_commit_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (head_valid && !q_empty),
        .head_done  (head_done),
        .head_exc   (head_exc),
        .retire     (retire),
        .flush_go   (flush_go),
        .accept     (accept)
    );

    assign commit_valid   = retire;
    assign commit_idx     = head_idx;
    assign commit_arch    = head_info.arch;
    assign commit_new_tag = head_info.new_tag;
    assign free_valid     = retire && head_info.has_dest;
    assign free_tag       = head_info.old_tag;
    assign mem_release    = retire && head_info.is_mem;
    assign flush          = flush_go;
    assign redirect_pc    = PC_W'(HANDLER_PC);

endmodule

// File: rtl/rob_commit_chk.sv
module rob_commit_chk #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic [IDX_W-1:0] alloc_idx,
    input logic             commit_valid,
    input logic [IDX_W-1:0] commit_idx,
    input logic             free_valid,
    input logic             mem_release,
    input logic             flush
);
    logic [CNT_W-1:0] occ_q;
    logic [IDX_W-1:0] exp_head_q;
    logic [IDX_W-1:0] exp_tail_q;
    logic             took;

    assign took = alloc_valid && alloc_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q      <= '0;
            exp_head_q <= '0;
            exp_tail_q <= '0;
        end else if (flush) begin
            occ_q      <= '0;
            exp_tail_q <= exp_head_q;
        end else begin
            occ_q <= occ_q + CNT_W'(took) - CNT_W'(commit_valid);
            if (took)         exp_tail_q <= exp_tail_q + IDX_W'(1);
            if (commit_valid) exp_head_q <= exp_head_q + IDX_W'(1);
        end
    end

    assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == CNT_W'(DEPTH)) |-> !alloc_ready);

    assert_alloc_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        took |-> (alloc_idx == exp_tail_q));

    assert_commit_oldest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> (commit_idx == exp_head_q));

    assert_no_commit_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == '0) |-> !commit_valid);

    assert_free_needs_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |-> commit_valid);

    assert_mem_needs_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_release |-> commit_valid);

    assert_flush_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!commit_valid && !alloc_ready));

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!commit_valid && !flush));

endmodule

bind rob_commit rob_commit_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/rob_commit_tb.sv
module rob_commit_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] HANDLER = 32'h0000_0180;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_valid = 1'b0;
    logic       alloc_has_dest = 1'b0;
    logic [4:0] alloc_arch = '0;
    logic [5:0] alloc_new_tag = '0;
    logic [5:0] alloc_old_tag = '0;
    logic       alloc_is_mem = 1'b0;
    logic       alloc_ready;
    logic [3:0] alloc_idx;
    logic       cmpl_valid = 1'b0;
    logic [3:0] cmpl_idx = '0;
    logic       cmpl_exc = 1'b0;
    logic       commit_valid;
    logic [3:0] commit_idx;
    logic [4:0] commit_arch;
    logic [5:0] commit_new_tag;
    logic       free_valid;
    logic [5:0] free_tag;
    logic       mem_release;
    logic       flush;
    logic [31:0] redirect_pc;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rob_commit u_dut (.*);

    function automatic logic [4:0] k_arch(int k);    return 5'(k + 1);  endfunction
    function automatic logic [5:0] k_new(int k);     return 6'(k + 40); endfunction
    function automatic logic [5:0] k_old(int k);     return 6'(k + 2);  endfunction
    function automatic logic       k_dest(int k);    return (k % 4) != 3; endfunction
    function automatic logic       k_mem(int k);     return (k % 3) == 0; endfunction

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic alloc_one(input int k, input int exp_idx);
        alloc_valid    = 1'b1;
        alloc_has_dest = k_dest(k);
        alloc_arch     = k_arch(k);
        alloc_new_tag  = k_new(k);
        alloc_old_tag  = k_old(k);
        alloc_is_mem   = k_mem(k);
        #1;
        check(alloc_ready == 1'b1, "R2 ready", alloc_ready, 1);
        check(alloc_idx == 4'(exp_idx), "R2 idx", alloc_idx, exp_idx);
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic cmpl_one(input int idx, input logic exc);
        cmpl_valid = 1'b1;
        cmpl_idx   = 4'(idx);
        cmpl_exc   = exc;
        @(negedge clk);
        cmpl_valid = 1'b0;
        cmpl_exc   = 1'b0;
    endtask

    task automatic check_commit(input int k, input int idx, input string req);
        check(commit_valid == 1'b1, {req, " valid"}, commit_valid, 1);
        check(commit_idx == 4'(idx), {req, " idx"}, commit_idx, idx);
        check(commit_arch == k_arch(k), "R5 arch", commit_arch, k_arch(k));
        check(commit_new_tag == k_new(k), "R5 new tag", commit_new_tag, k_new(k));
        if (k_dest(k)) begin
            check(free_valid == 1'b1, "R5 free valid", free_valid, 1);
            check(free_tag == k_old(k), "R5 free tag", free_tag, k_old(k));
        end else begin
            check(free_valid == 1'b0, "R6 no free", free_valid, 0);
        end
        check(mem_release == k_mem(k), "R7 mem release", mem_release, k_mem(k));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(alloc_ready == 1'b1, "R1 ready", alloc_ready, 1);
        check(commit_valid == 1'b0, "R1 commit", commit_valid, 0);
        check(free_valid == 1'b0, "R1 free", free_valid, 0);
        check(mem_release == 1'b0, "R1 mem", mem_release, 0);
        check(flush == 1'b0, "R1 flush", flush, 0);

        // R2 fill all slots in order
        for (int k = 0; k < 16; k++) alloc_one(k, k);
        check(alloc_ready == 1'b0, "R2 full", alloc_ready, 0);

        // R3 younger finished slots must wait for the oldest
        for (int k = 15; k >= 1; k--) begin
            cmpl_one(k, 1'b0);
            check(commit_valid == 1'b0, "R3 wait oldest", commit_valid, 0);
        end
        cmpl_one(0, 1'b0);
        // R10 one retirement per cycle, back to back
        for (int k = 0; k < 16; k++) begin
            check_commit(k, k, "R10");
            @(negedge clk);
        end
        check(commit_valid == 1'b0, "R3 empty", commit_valid, 0);
        check(alloc_ready == 1'b1, "R2 ready after drain", alloc_ready, 1);

        // R4 completion to an unheld slot is ignored
        cmpl_one(5, 1'b0);
        for (int k = 0; k < 8; k++) alloc_one(k, k);
        cmpl_one(6, 1'b0);
        cmpl_one(7, 1'b0);
        for (int k = 0; k < 5; k++) cmpl_one(k, 1'b0);
        check_commit(4, 4, "R3");
        @(negedge clk);
        check(commit_valid == 1'b0, "R4 stale completion", commit_valid, 0);
        @(negedge clk);
        check(commit_valid == 1'b0, "R4 still waiting", commit_valid, 0);

        // R8 fault at the head
        cmpl_one(5, 1'b1);
        check(commit_valid == 1'b0, "R8 no retire", commit_valid, 0);
        check(flush == 1'b0, "R8 flush timing", flush, 0);
        @(negedge clk);
        check(flush == 1'b1, "R8 flush", flush, 1);
        check(redirect_pc == HANDLER, "R8 redirect", redirect_pc, HANDLER);
        check(alloc_ready == 1'b0, "R8 alloc blocked", alloc_ready, 0);
        check(commit_valid == 1'b0, "R8 no commit in flush", commit_valid, 0);
        @(negedge clk);
        // R9 queue emptied, younger finished slots gone
        check(flush == 1'b0, "R9 flush one cycle", flush, 0);
        check(commit_valid == 1'b0, "R9 empty", commit_valid, 0);
        check(alloc_ready == 1'b1, "R9 ready", alloc_ready, 1);
        alloc_one(7, 5);
        check(commit_valid == 1'b0, "R9 younger discarded", commit_valid, 0);
        cmpl_one(5, 1'b0);
        check_commit(7, 5, "R9");
        @(negedge clk);
        check(commit_valid == 1'b0, "R9 single entry", commit_valid, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule